// File: doc/BRIEF.md
# Biased Byte Dot-Product Unit

This block multiplies two packed operands lane by lane and adds up the products. Each 32-bit operand holds four bytes. Before the multiply, every byte is widened to a signed value and an offset for that operand is added to it. Each operand has its own signedness flag, so signed and unsigned bytes can be mixed. Each operand also has its own 9-bit two's-complement offset. The four lane products are summed exactly and the result is returned as a 32-bit two's-complement word.

The result is held in a single output register. A caller presents the operands, offsets and flags together with `in_valid`. One clock later the sum appears on `out_result` and `out_valid` goes high. While `in_valid` is low, the output register keeps its last value. The block does not accumulate across cycles and does not saturate.

Top module: `bdot_unit`

## Requirements
- R1: Operand lane i is taken from bits 8i+7 down to 8i of `op_a` and of `op_b`. Lane i of `op_a` is paired only with lane i of `op_b`.
- R2: When `sgn_a` (or `sgn_b`) is 1, the bytes of that operand are sign-extended, so 0x80 counts as -128 and 0xFF as -1. When the flag is 0 they are zero-extended, so 0x80 counts as 128 and 0xFF as 255.
- R3: `bias_a` and `bias_b` are 9-bit two's-complement values. 0x100 means -256, 0x0FF means +255 and 0x1FF means -1. The offset of an operand is added to every byte of that operand.
- R4: `out_result` equals the sum over the four lanes of (a_byte + bias_a) × (b_byte + bias_b), computed in signed arithmetic and given as 32-bit two's complement. If `op_a` is zero and `bias_a` is zero, the result is 0.
- R5: The result is exact for every input combination. Its magnitude never exceeds 1040400, which is 4 × 510².
- R6: `out_valid` is `in_valid` delayed by one clock.
- R7: `out_result` changes only in the cycle after `in_valid` was high. Otherwise it keeps its value.
- R8: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present; capture the sum |
| op_a | input | 32 | First packed operand, four bytes |
| op_b | input | 32 | Second packed operand, four bytes |
| bias_a | input | 9 | Two's-complement offset added to each byte of `op_a` |
| bias_b | input | 9 | Two's-complement offset added to each byte of `op_b` |
| sgn_a | input | 1 | 1: bytes of `op_a` are signed |
| sgn_b | input | 1 | 1: bytes of `op_b` are signed |
| out_valid | output | 1 | Result register was loaded on the last edge |
| out_result | output | 32 | Registered dot product |

## Verification
The assertions assume that all inputs are driven to known values whenever `in_valid` is high.

The zero-operand property also assumes that `op_a` and `bias_a` are sampled on the same edge as `in_valid`. The bench meets this by changing every input just after an edge.

The magnitude bound holds only because `bias_a` and `bias_b` are confined to 9 bits. The sweeps use the offset extremes -256 and +255, together with -1 and 0, paired with every byte value and every sign combination. This drives the result to both ends of its range without leaving the range the bound assumes.

// File: rtl/bdot_pkg.sv
package bdot_pkg;

    localparam int LANE_W = 8;
    localparam int BIAS_W = 9;
    localparam int LANES  = 4;
    localparam int OUT_W  = 32;
    localparam int TERM_W = (LANE_W > BIAS_W ? LANE_W : BIAS_W) + 1;
    localparam int PROD_W = 2 * TERM_W;

    // largest lane product: both terms at the positive extreme, or both at the negative extreme
    localparam int POS_TERM = (2 ** LANE_W - 1) + (2 ** (BIAS_W - 1) - 1);
    localparam int NEG_TERM = (2 ** (LANE_W - 1)) + (2 ** (BIAS_W - 1));
    localparam int LANE_MAX = (POS_TERM > NEG_TERM) ? POS_TERM * POS_TERM
                                                    : NEG_TERM * NEG_TERM;

    typedef logic        [LANE_W-1:0] lane_t;
    typedef logic signed [BIAS_W-1:0] bias_t;
    typedef logic signed [TERM_W-1:0] term_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic        [OUT_W-1:0]  result_t;

    typedef struct packed {
        logic  sgn;
        bias_t bias;
    } opnd_cfg_t;

    typedef struct packed {
        logic    vld;
        result_t val;
    } out_stage_t;

    // widen a byte by its signedness and add the operand offset
    function automatic term_t lane_term(lane_t v, opnd_cfg_t c);
        term_t ext;
        term_t bx;
        ext = {{(TERM_W - LANE_W){c.sgn & v[LANE_W-1]}}, v};
        bx  = {{(TERM_W - BIAS_W){c.bias[BIAS_W-1]}}, c.bias};
        return ext + bx;
    endfunction

endpackage

// File: rtl/bdot_lane.sv
module bdot_lane
    import bdot_pkg::*;
(
    input  lane_t     a_byte,
    input  lane_t     b_byte,
    input  opnd_cfg_t a_cfg,
    input  opnd_cfg_t b_cfg,
    output prod_t     prod
);
    term_t ta;
    term_t tb;

    assign ta   = lane_term(a_byte, a_cfg);
    assign tb   = lane_term(b_byte, b_cfg);
    assign prod = PROD_W'(ta) * PROD_W'(tb);
endmodule

// File: rtl/bdot_sum.sv
module bdot_sum
    import bdot_pkg::*;
#(
    parameter int N = 4
) (
    input  prod_t   prods [N],
    output result_t sum
);
    localparam int SUM_W = PROD_W + $clog2(N) + 1;

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + SUM_W'(prods[i]);
        end
        sum = OUT_W'(acc);
    end
endmodule

// File: rtl/bdot_outreg.sv
module bdot_outreg
    import bdot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  result_t    d,
    output out_stage_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= load;
            if (load) begin
                q.val <= d;
            end
        end
    end
endmodule

// File: rtl/bdot_unit.sv
module bdot_unit
    import bdot_pkg::*;
#(
    parameter int N_LANES = LANES,
    localparam int OPW    = N_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    input  logic [BIAS_W-1:0] bias_a,
    input  logic [BIAS_W-1:0] bias_b,
    input  logic              sgn_a,
    input  logic              sgn_b,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_result
);
    opnd_cfg_t  cfg_a;
    opnd_cfg_t  cfg_b;
    prod_t      lane_prod [N_LANES];
    result_t    comb_sum;
    out_stage_t stage;

    assign cfg_a = '{sgn: sgn_a, bias: bias_a};
    assign cfg_b = '{sgn: sgn_b, bias: bias_b};

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        bdot_lane lane_i (
            .a_byte (op_a[i*LANE_W +: LANE_W]),
            .b_byte (op_b[i*LANE_W +: LANE_W]),
            .a_cfg  (cfg_a),
            .b_cfg  (cfg_b),
            .prod   (lane_prod[i])
        );
    end

    bdot_sum #(.N(N_LANES)) sum_i (
        .prods (lane_prod),
        .sum   (comb_sum)
    );

    bdot_outreg reg_i (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .d    (comb_sum),
        .q    (stage)
    );

    assign out_valid  = stage.vld;
    assign out_result = stage.val;
endmodule

// File: rtl/bdot_unit_chk.sv
module bdot_unit_chk
    import bdot_pkg::*;
#(
    parameter int N_LANES = LANES,
    localparam int OPW    = N_LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OPW-1:0]    op_a,
    input logic [BIAS_W-1:0] bias_a,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_result
);
    localparam int RES_MAX = N_LANES * LANE_MAX;

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));

    // R4
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a == '0 && bias_a == '0) |=> (out_result == '0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_result) <= RES_MAX && $signed(out_result) >= -RES_MAX));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind bdot_unit bdot_unit_chk #(.N_LANES(N_LANES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .bias_a     (bias_a),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/bdot_unit_tb_top.sv
`timescale 1ns/1ps
module bdot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [8:0]  bias_a = '0;
    logic [8:0]  bias_b = '0;
    logic        sgn_a = 1'b0;
    logic        sgn_b = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] last_exp = '0;

    always #2 clk = ~clk;

    bdot_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .bias_a(bias_a), .bias_b(bias_b),
        .sgn_a(sgn_a), .sgn_b(sgn_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic int ref_dot(logic [31:0] a, logic [31:0] b,
                                   logic [8:0] ba, logic [8:0] bb, bit sa, bit sb);
        int acc = 0;
        int oa = int'(ba);
        int ob = int'(bb);
        if (oa >= 256) oa -= 512;
        if (ob >= 256) ob -= 512;
        for (int i = 0; i < 4; i++) begin
            int x = int'(a[8*i +: 8]);
            int y = int'(b[8*i +: 8]);
            if (sa && x >= 128) x -= 256;
            if (sb && y >= 128) y -= 256;
            acc += (x + oa) * (y + ob);
        end
        return acc;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apply(string req, logic [31:0] a, logic [31:0] b,
                         logic [8:0] ba, logic [8:0] bb, bit sa, bit sb);
        logic [31:0] exp;
        exp = 32'(ref_dot(a, b, ba, bb, sa, sb));
        op_a = a; op_b = b; bias_a = ba; bias_b = bb; sgn_a = sa; sgn_b = sb;
        in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check("R6 valid", {31'd0, out_valid}, 32'd1);
        check(req, out_result, exp);
        last_exp = exp;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        logic [8:0] bset [4];
        bset[0] = 9'h000;
        bset[1] = 9'h100;
        bset[2] = 9'h0FF;
        bset[3] = 9'h1FF;

        repeat (3) @(posedge clk);
        #1;
        check("R8 valid", {31'd0, out_valid}, 32'd0);
        check("R8 result", out_result, 32'd0);
        rst = 1'b0;

        // R1: one nonzero lane at a time
        for (int i = 0; i < 4; i++) begin
            apply("R1 lane", 32'(5) << (8 * i), 32'h04030201, 9'h000, 9'h000, 1'b0, 1'b0);
            check("R1 lane value", last_exp, 32'(5 * (i + 1)));
        end

        // R2: signedness of extreme bytes
        apply("R2 unsigned 80", 32'h80808080, 32'h01010101, 9'h000, 9'h000, 1'b0, 1'b0);
        check("R2 u80", last_exp, 32'd512);
        apply("R2 signed 80", 32'h80808080, 32'h01010101, 9'h000, 9'h000, 1'b1, 1'b0);
        check("R2 s80", last_exp, -32'sd512);
        apply("R2 signed FF", 32'h01010101, 32'hFFFFFFFF, 9'h000, 9'h000, 1'b0, 1'b1);
        apply("R2 unsigned FF", 32'h01010101, 32'hFFFFFFFF, 9'h000, 9'h000, 1'b0, 1'b0);

        // R3: offset extremes
        apply("R3 bias -256", 32'h00000000, 32'h01010101, 9'h100, 9'h000, 1'b0, 1'b0);
        check("R3 m256", last_exp, -32'sd1024);
        apply("R3 bias +255", 32'h00000000, 32'h00000000, 9'h0FF, 9'h0FF, 1'b0, 1'b0);

        // R5: magnitude extremes
        apply("R5 max pos", 32'hFFFFFFFF, 32'hFFFFFFFF, 9'h0FF, 9'h0FF, 1'b0, 1'b0);
        check("R5 max value", last_exp, 32'd1040400);
        apply("R5 max neg side", 32'h80808080, 32'h80808080, 9'h100, 9'h100, 1'b1, 1'b1);
        apply("R5 negative", 32'hFFFFFFFF, 32'h80808080, 9'h0FF, 9'h100, 1'b0, 1'b1);

        // R4: zero operand and zero offset
        apply("R4 zero", 32'h0, 32'h12345678, 9'h000, 9'h0FF, 1'b1, 1'b1);

        // R7: operands change with in_valid low
        op_a = 32'hDEADBEEF; op_b = 32'h7F7F7F7F; bias_a = 9'h123; sgn_a = 1'b1;
        @(posedge clk); #1;
        check("R6 idle valid", {31'd0, out_valid}, 32'd0);
        check("R7 hold", out_result, last_exp);
        @(posedge clk); #1;
        check("R7 hold again", out_result, last_exp);

        // R4: sweep every byte value, sign combination and offset pair
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [7:0] v0 = 8'(v);
                    logic [7:0] v1 = 8'(v + 37);
                    logic [7:0] v2 = 8'(v * 3 + 128);
                    logic [7:0] v3 = 8'(255 - v);
                    apply("R4 sweep", {v3, v2, v1, v0}, {~v1, v0, ~v3, v2},
                          bset[p % 4], bset[p / 4], s[0], s[1]);
                end
            end
        end

        // R4: random operands
        for (int k = 0; k < 3000; k++) begin
            apply("R4 random", $urandom, $urandom, 9'($urandom), 9'($urandom),
                  1'($urandom), 1'($urandom));
        end

        // R8: reset clears after activity
        rst = 1'b1;
        @(posedge clk); #1;
        check("R8 reset valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset result", out_result, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule